// File: doc/BRIEF.md
# Floppy Flux Interval Capture

This block sits between a floppy drive's read-data line and a byte FIFO that feeds a host link. A start strobe opens a fixed capture window that lasts a little longer than one disk revolution, long enough to cover a whole track. During the window the block times the gap between consecutive falling edges on the read line and pushes each gap into the FIFO as one byte, as soon as it is known. Each byte is a count of ticks at a fixed sub-rate of the system clock, nominally 20 MHz. The FIFO can drain toward the host while the capture is still running. The block does not decode the data: the host turns the stream of intervals into bits.

The read line is asynchronous, so it first passes through a two-flop synchronizer. A falling edge is seen when the older sample is high and the newer one is low. The first edge after a start only sets the phase of the interval counter. Every later edge emits the count and restarts the counter. A gap too long for eight bits is reported as 255. If the FIFO is full when a byte is due, that byte is lost and a sticky overflow flag is raised. At the end of the window a single-cycle done pulse is given, and the read line is then ignored until the next start.

The controller has four states. IDLE waits for start. ARM waits for the first edge. MEASURE times and emits intervals. FINISH raises done. The transitions are:
- IDLE to ARM on start.
- ARM to MEASURE on the first edge.
- ARM or MEASURE to FINISH when the window expires.
- FINISH to IDLE unconditionally.

If the window expires in the same cycle as an edge, expiry wins and no byte is written.

Top module: `flux_interval_capture`

## Requirements
- R1: After reset, busy, done, fifo_wr and overflow are all 0.
- R2: A start in IDLE makes busy 1 on the next cycle. Counting from the clock edge that accepts the start, done rises exactly TICK_DIV*WINDOW_TICKS cycles later and stays high for one cycle, with busy 0 from that cycle on.
- R3: The first falling edge on rd_n after a start writes no byte.
- R4: Every later falling edge in the window writes one byte equal to the number of ticks (one per TICK_DIV clocks) since the previous falling edge. A gap of K clocks, with K a multiple of TICK_DIV, gives K/TICK_DIV. The width of the low phase has no effect.
- R5: An interval longer than 255 ticks is written as 255, and the next interval counts from zero again.
- R6: If fifo_full is 1 when a byte is due, no write occurs and overflow becomes 1. It stays 1, including after done, until the next accepted start clears it. The timing of later intervals is unaffected by the drop.
- R7: Falling edges while idle, before any start or after done, write nothing and leave busy at 0.
- R8: A start while busy is ignored, and the window still ends at the time set by the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Raw asynchronous read-data line from the drive, pulses low |
| start | input | 1 | One-cycle request to begin a capture |
| fifo_full | input | 1 | Downstream FIFO cannot accept a byte |
| fifo_data | output | 8 | Interval byte in ticks |
| fifo_wr | output | 1 | Write strobe for fifo_data |
| busy | output | 1 | Capture window open (ARM or MEASURE) |
| done | output | 1 | One-cycle pulse at window end |
| overflow | output | 1 | Sticky flag: a byte was dropped on a full FIFO |

## Verification
The assertions assume the following about the inputs:
- reset is applied before any check matters;
- start is only acted on outside a capture;
- fifo_full is a level that the FIFO holds steady within a cycle.

Under those assumptions, a written byte never meets a full FIFO, and a falling edge is never detected in two cycles in a row. The stimulus drives rd_n, start and fifo_full only at the falling clock edge. It holds each low pulse for two cycles, so the synchronizer always sees a clean edge. It spaces edges by multiples of the tick period, so every expected count is exact whatever the prescaler phase. It also keeps every edge clear of the window's end, so the expiry-versus-edge tie never decides a result.

// File: rtl/floppy_cap_pkg.sv
package floppy_cap_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE    = 2'd0,
        CAP_ARM     = 2'd1,
        CAP_MEASURE = 2'd2,
        CAP_FINISH  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/flux_edge_sync.sv
module flux_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic rd_n,
    output logic fall
);
    logic s_new;
    logic s_old;

    // Two-stage synchronizer; reset to the idle-high level of the line.
    always_ff @(posedge clk) begin
        if (rst) begin
            s_new <= 1'b1;
            s_old <= 1'b1;
        end else begin
            s_new <= rd_n;
            s_old <= s_new;
        end
    end

    assign fall = s_old & ~s_new;

    // R4: a single low pulse yields exactly one detection
    p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int TICK_DIV = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || restart) pre <= '0;
        else if (pre == PLAST) pre <= '0;
        else pre <= pre + 1'b1;
    end

    assign tick = (pre == PLAST);

    // R4: ticks never come back to back
    p_tick_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // Clearing restarts from the current cycle so the count covers the
    // half-open span between two edges.
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else if (clear) count <= tick ? CNT_W'(1) : '0;
        else if (tick && (count != CMAX)) count <= count + 1'b1;
    end

    // R5: saturated value holds until cleared
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (count == CMAX && !clear) |=> (count == CMAX));
endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int WINDOW_TICKS = 4_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int WW = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
    localparam logic [WW-1:0] WLAST = WW'(WINDOW_TICKS - 1);

    logic [WW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || restart) wcnt <= '0;
        else if (tick) wcnt <= (wcnt == WLAST) ? '0 : wcnt + 1'b1;
    end

    assign expire = tick && (wcnt == WLAST);

    // R2: after expiry the timer starts a fresh window
    p_expire_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (expire && !restart) |=> (wcnt == '0));
endmodule

// File: rtl/flux_interval_capture.sv
module flux_interval_capture
    import floppy_cap_pkg::*;
#(
    parameter int TICK_DIV     = 5,
    parameter int WINDOW_TICKS = 4_500_000,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              start,
    input  logic              fifo_full,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_wr,
    output logic              busy,
    output logic              done,
    output logic              overflow
);
    cap_state_e        state_q;
    cap_state_e        state_d;
    logic              fall;
    logic              tick;
    logic              expire;
    logic              accept;
    logic              due;
    logic [DATA_W-1:0] count;

    assign accept = (state_q == CAP_IDLE) && start;
    assign due    = (state_q == CAP_MEASURE) && fall && !expire;

    flux_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .rd_n (rd_n),
        .fall (fall)
    );

    tick_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick)
    );

    interval_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (fall),
        .tick  (tick),
        .count (count)
    );

    window_timer #(.WINDOW_TICKS(WINDOW_TICKS)) u_win (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick),
        .expire  (expire)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CAP_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:    if (start) state_d = CAP_ARM;
            CAP_ARM:     if (expire) state_d = CAP_FINISH;
                         else if (fall) state_d = CAP_MEASURE;
            CAP_MEASURE: if (expire) state_d = CAP_FINISH;
            CAP_FINISH:  state_d = CAP_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q == CAP_ARM) || (state_q == CAP_MEASURE);
        done      = (state_q == CAP_FINISH);
        fifo_wr   = due && !fifo_full;
        fifo_data = count;
    end

    // Sticky drop flag
    always_ff @(posedge clk) begin
        if (rst)                  overflow <= 1'b0;
        else if (accept)          overflow <= 1'b0;
        else if (due && fifo_full) overflow <= 1'b1;
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);
    p_done_once_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    p_wr_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> busy);
    p_no_wr_full_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !fifo_full);
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (overflow && !(start && !busy && !done)) |=> overflow);
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy || done));
endmodule

// File: tb/flux_interval_capture_bench.sv
`timescale 1ns/1ps
module flux_interval_capture_bench;
    localparam int DIV = 4;
    localparam int WIN = 600;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_n = 1'b1;
    logic       start = 1'b0;
    logic       fifo_full = 1'b0;
    logic [7:0] fifo_data;
    logic       fifo_wr;
    logic       busy;
    logic       done;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int wr_val [0:15];
    bit finished = 0;

    always #2 clk = ~clk;

    flux_interval_capture #(.TICK_DIV(DIV), .WINDOW_TICKS(WIN)) u_flux_interval_capture (
        .clk(clk), .rst(rst), .rd_n(rd_n), .start(start), .fifo_full(fifo_full),
        .fifo_data(fifo_data), .fifo_wr(fifo_wr), .busy(busy), .done(done),
        .overflow(overflow)
    );

    always @(negedge clk) begin
        #1;
        if (fifo_wr) begin
            if (wr_cnt < 16) wr_val[wr_cnt] = int'(fifo_data);
            wr_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic edge_gap(input int gap);
        repeat (gap - 2) @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 5000);
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!busy && !done && !fifo_wr && !overflow, "R1 idle outputs",
              {busy, done, fifo_wr, overflow}, 0);
        wr_cnt = 0;
        edge_gap(10); edge_gap(16); edge_gap(24);
        repeat (4) @(negedge clk);
        check(wr_cnt == 0, "R7 edges before start", wr_cnt, 0);
        check(!busy, "R7 busy before start", busy, 0);
        n = 0;
    endtask

    task automatic t_window();
        int n;
        do_start();
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_done(n);
        check(n == DIV * WIN, "R2 window length", n, DIV * WIN);
        @(negedge clk);
        check(!done && !busy, "R2 done one cycle", {done, busy}, 0);
    endtask

    task automatic t_intervals();
        int n;
        int exp_v [0:4] = '{4, 6, 8, 5, 7};
        wr_cnt = 0;
        do_start();
        edge_gap(8);
        repeat (6) @(negedge clk);
        check(wr_cnt == 0, "R3 first edge arms only", wr_cnt, 0);
        edge_gap(16 - 6); edge_gap(24); edge_gap(32); edge_gap(20); edge_gap(28);
        repeat (4) @(negedge clk);
        check(wr_cnt == 5, "R4 write count", wr_cnt, 5);
        for (int i = 0; i < 5; i++)
            check(wr_val[i] == exp_v[i], "R4 interval value", wr_val[i], exp_v[i]);
        wait_done(n);
    endtask

    task automatic t_saturate();
        int n;
        wr_cnt = 0;
        do_start();
        edge_gap(8); edge_gap(1100); edge_gap(16);
        repeat (4) @(negedge clk);
        check(wr_cnt == 2, "R5 write count", wr_cnt, 2);
        check(wr_val[0] == 255, "R5 saturated value", wr_val[0], 255);
        check(wr_val[1] == 4, "R5 restart after saturation", wr_val[1], 4);
        wait_done(n);
    endtask

    task automatic t_full();
        int n;
        wr_cnt = 0;
        do_start();
        check(!overflow, "R6 flag clear at start", overflow, 0);
        edge_gap(8); edge_gap(16);
        fifo_full = 1'b1;
        edge_gap(24);
        repeat (2) @(negedge clk);
        fifo_full = 1'b0;
        check(overflow == 1'b1, "R6 flag set on drop", overflow, 1);
        edge_gap(30);
        repeat (4) @(negedge clk);
        check(wr_cnt == 2, "R6 dropped byte", wr_cnt, 2);
        check(wr_val[1] == 8, "R6 timing after drop", wr_val[1], 8);
        wait_done(n);
        @(negedge clk);
        check(overflow == 1'b1, "R6 flag sticky after done", overflow, 1);
        do_start();
        check(!overflow, "R6 flag cleared by start", overflow, 0);
        wait_done(n);
    endtask

    task automatic t_after_done();
        wr_cnt = 0;
        @(negedge clk);
        edge_gap(16); edge_gap(16); edge_gap(20);
        repeat (4) @(negedge clk);
        check(wr_cnt == 0, "R7 edges after done", wr_cnt, 0);
        check(!busy, "R7 busy after done", busy, 0);
    endtask

    task automatic t_busy_start();
        int n;
        int total;
        do_start();
        total = 0;
        repeat (998) begin @(negedge clk); total++; end
        start = 1'b1;
        @(negedge clk); total++;
        start = 1'b0;
        wait_done(n);
        total += n;
        check(total == DIV * WIN, "R8 window kept", total, DIV * WIN);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_window();
        t_intervals();
        t_saturate();
        t_full();
        t_after_done();
        t_busy_start();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule